// File: doc/BRIEF.md
# Write-Invalidate Snooping Cache Controller

This block is one processor's private cache on a shared bus, together with the logic that keeps it coherent with the other caches on that bus. The cache is direct mapped. Each line holds a tag, a data word and a 2-bit coherence state. Processor accesses are looked up by tag. Read hits, and write hits on lines no other cache holds, finish in the cycle of the request. Misses, and writes to shared lines, go through a single bus command issued by the controller.

The block watches every command that the other caches place on the bus. When it holds a valid copy of the addressed line, it reports that it shares the line. When it holds a modified copy, it hands the data over so that the requester and memory both receive it. It drops its copy when another cache announces a write. A write to a line that no other cache holds causes no bus traffic. A modified line that must make room for a new tag is written back before the new line is fetched.

The processor holds its request until `cpu_ready`. The bus owner grants one command at a time. It then ends that command with `bus_done`, returning fill data and whether any other cache reported a copy.

Top module: `wi_snoop_cache`

## Requirements
- R1: Line states are coded invalid=2'b00, sole clean=2'b01, shared clean=2'b10, sole modified=2'b11. After reset every line is invalid, so the first read of any address misses.
- R2: A read miss whose completion reports no other copy (`bus_shared_in`=0) installs the line sole clean. A later write to it then needs no bus command.
- R3: A read miss whose completion reports another copy (`bus_shared_in`=1) installs the line shared clean. A later write to it then issues an invalidate command.
- R4: A snooped read-miss to a line held sole modified raises `snp_shared` and `snp_supply` and drives the line's data on `snp_data` in the same cycle. From the next cycle the line is shared clean.
- R5: A write miss issues a write-miss command and fills from `bus_rdata`. The line becomes sole modified and then holds the processor's write data.
- R6: A write hit on a sole modified line is done locally, with no bus command, and the line stays sole modified.
- R7: A write hit on a sole clean line is done locally with no bus command, and the line becomes sole modified.
- R8: A write hit on a shared clean line first issues an invalidate command and waits for its completion. It then performs the write, and the line becomes sole modified.
- R9: A read hit in any valid state returns the line data in the request cycle, issues no command and leaves the state unchanged.
- R10: For a snooped command, the line matches only if it is valid and its tag equals the command's tag. A matching snooped invalidate or write-miss invalidates the line from the next cycle. A snooped write-miss to a sole modified line also supplies its data. `snp_shared` is raised for matching read-miss and write-miss commands only.
- R11: Bus command codes are read-miss=0, write-miss=1, invalidate=2, write-back=3. `bus_req` stays high until `bus_gnt` and then drops. The controller waits for `bus_done` before it issues anything else.
- R12: A miss that displaces a sole modified line first issues a write-back, carrying the old address and data, and then the miss command. A displaced clean line is dropped without a command.
- R13: `cpu_hit` is high with `cpu_ready` only when the request's first lookup found a valid line with a matching tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: tag above index |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Access hit on its first lookup |
| cpu_rdata | output | DATA_W | Line data, valid with cpu_ready |
| bus_req | output | 1 | Bus command pending |
| bus_cmd | output | 2 | Command code |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Data for a write-back |
| bus_gnt | input | 1 | Command accepted by the bus |
| bus_done | input | 1 | Current command finished |
| bus_rdata | input | DATA_W | Fill data at completion |
| bus_shared_in | input | 1 | Another cache reported a copy |
| snp_vld | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a valid matching copy |
| snp_supply | output | 1 | This cache provides modified data |
| snp_data | output | DATA_W | Supplied data |

## Verification
The embedded properties check the bus handshake on every cycle. They confirm that a pending request is held until it is granted, that it drops after the grant, and that a clean unshared write never raises a request. They also check that supply never occurs without a shared copy, and that a snooped write-miss leaves no copy behind in the following cycle. The state transitions themselves are invisible at the ports. Only the directed scenarios can reveal them, by following each state-changing event with a probe whose outcome depends on the new state. Such a probe is a write that does or does not need the bus, or a snooped read that does or does not get data supplied. The write-back ordering on eviction is also shown only by those scenarios.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SC  = 2'b01,
      LN_MC  = 2'b10,
      LN_SI  = 2'b11
   } line_st_e;

   typedef enum logic [1:0] {
      BC_RDMISS = 2'd0,
      BC_WRMISS = 2'd1,
      BC_INVAL  = 2'd2,
      BC_WRBACK = 2'd3
   } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 5,
   parameter int DATA_W = 32,
   localparam int NLINES = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   output logic [1:0]        lk_st,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [DATA_W-1:0] lk_data,
   input  logic [IDX_W-1:0]  sn_idx,
   output logic [1:0]        sn_st,
   output logic [TAG_W-1:0]  sn_tag,
   output logic [DATA_W-1:0] sn_data,
   input  logic              own_we,
   input  logic [IDX_W-1:0]  own_idx,
   input  logic [1:0]        own_st,
   input  logic [TAG_W-1:0]  own_tag,
   input  logic [DATA_W-1:0] own_data,
   input  logic              upd_we,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [1:0]        upd_st
);
   if (NLINES > 1024) begin : g_too_deep
      $error("coh_line_store: too many lines");
   end

   logic [1:0]        st_a   [NLINES];
   logic [TAG_W-1:0]  tag_a  [NLINES];
   logic [DATA_W-1:0] data_a [NLINES];

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      logic [1:0]        st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;
      logic              upd_hit, own_hit;

      assign upd_hit = upd_we && (upd_idx == IDX_W'(i));
      assign own_hit = own_we && (own_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q   <= LN_INV;
            tag_q  <= '0;
            data_q <= '0;
         end else if (upd_hit) begin
            st_q <= upd_st;
         end else if (own_hit) begin
            st_q   <= own_st;
            tag_q  <= own_tag;
            data_q <= own_data;
         end
      end

      assign st_a[i]   = st_q;
      assign tag_a[i]  = tag_q;
      assign data_a[i] = data_q;
   end

   assign lk_st   = st_a[lk_idx];
   assign lk_tag  = tag_a[lk_idx];
   assign lk_data = data_a[lk_idx];
   assign sn_st   = st_a[sn_idx];
   assign sn_tag  = tag_a[sn_idx];
   assign sn_data = data_a[sn_idx];
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
   import coh_pkg::*;
#(
   parameter int TAG_W  = 5,
   parameter int DATA_W = 32
) (
   input  logic              snp_vld,
   input  logic [1:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  logic [1:0]        ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              snp_shared,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_data,
   output logic              upd_we,
   output logic [1:0]        upd_st
);
   logic match, dirty;

   assign match = snp_vld && (ln_st != LN_INV) && (ln_tag == snp_tag);
   assign dirty = (ln_st == LN_SI);

   always_comb begin
      snp_shared = 1'b0;
      snp_supply = 1'b0;
      upd_we     = 1'b0;
      upd_st     = LN_INV;
      case (snp_cmd)
         BC_RDMISS: begin
            snp_shared = match;
            snp_supply = match && dirty;
            upd_we     = match && (ln_st != LN_MC);
            upd_st     = LN_MC;
         end
         BC_WRMISS: begin
            snp_shared = match;
            snp_supply = match && dirty;
            upd_we     = match;
            upd_st     = LN_INV;
         end
         BC_INVAL: begin
            upd_we = match;
            upd_st = LN_INV;
         end
         default: begin
            upd_we = 1'b0;
         end
      endcase
   end

   assign snp_data = snp_supply ? ln_data : '0;
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 32,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [1:0]        ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   input  logic              snp_block,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_shared_in,
   output logic              own_we,
   output logic [1:0]        own_st,
   output logic [TAG_W-1:0]  own_tag,
   output logic [DATA_W-1:0] own_data
);
   typedef enum logic [1:0] {CS_IDLE, CS_REQ, CS_WAIT} cs_e;

   cs_e              cs_q, cs_d;
   logic [1:0]       cmd_q;
   logic             miss_q;
   logic [TAG_W-1:0] cpu_tag;
   logic [IDX_W-1:0] cpu_idx;
   logic             tag_eq, line_hit, accept;

   assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
   assign cpu_idx  = cpu_addr[IDX_W-1:0];
   assign tag_eq   = (ln_tag == cpu_tag);
   assign line_hit = (ln_st != LN_INV) && tag_eq;
   assign accept   = (cs_q == CS_IDLE) && cpu_req && !snp_block;

   always_comb begin
      cs_d      = cs_q;
      cpu_ready = 1'b0;
      bus_req   = 1'b0;
      bus_cmd   = BC_RDMISS;
      bus_addr  = cpu_addr;
      bus_wdata = '0;
      own_we    = 1'b0;
      own_st    = LN_INV;
      own_tag   = cpu_tag;
      own_data  = cpu_wdata;
      case (cs_q)
         CS_IDLE: begin
            if (accept) begin
               if (line_hit && !cpu_we) begin
                  cpu_ready = 1'b1;
               end else if (line_hit && (ln_st != LN_MC)) begin
                  cpu_ready = 1'b1;
                  own_we    = 1'b1;
                  own_st    = LN_SI;
               end else begin
                  cs_d = CS_REQ;
               end
            end
         end
         CS_REQ: begin
            bus_req = 1'b1;
            if ((ln_st == LN_SI) && !tag_eq) begin
               bus_cmd   = BC_WRBACK;
               bus_addr  = {ln_tag, cpu_idx};
               bus_wdata = ln_data;
            end else if (line_hit && cpu_we) begin
               bus_cmd = BC_INVAL;
            end else if (cpu_we) begin
               bus_cmd = BC_WRMISS;
            end else begin
               bus_cmd = BC_RDMISS;
            end
            if (bus_gnt) cs_d = CS_WAIT;
         end
         CS_WAIT: begin
            if (bus_done) begin
               own_we = 1'b1;
               cs_d   = CS_IDLE;
               case (cmd_q)
                  BC_RDMISS: begin
                     own_st   = bus_shared_in ? LN_MC : LN_SC;
                     own_data = bus_rdata;
                  end
                  BC_WRMISS: begin
                     own_st   = LN_SI;
                     own_data = bus_rdata;
                  end
                  BC_INVAL: begin
                     own_st   = LN_SI;
                     own_tag  = ln_tag;
                     own_data = ln_data;
                  end
                  default: begin
                     own_st   = LN_INV;
                     own_tag  = ln_tag;
                     own_data = ln_data;
                  end
               endcase
            end
         end
         default: cs_d = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= CS_IDLE;
         cmd_q  <= BC_RDMISS;
         miss_q <= 1'b0;
      end else begin
         cs_q <= cs_d;
         if ((cs_q == CS_REQ) && bus_gnt) cmd_q <= bus_cmd;
         if (cpu_ready)                   miss_q <= 1'b0;
         else if (accept && !line_hit)    miss_q <= 1'b1;
      end
   end

   assign cpu_hit   = cpu_ready && !miss_q;
   assign cpu_rdata = ln_data;

   // R11: a pending command stays requested until granted
   a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt |=> bus_req);

   // R11: after a grant nothing new is requested before completion
   a_r11_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt |=> !bus_req);

   // R7: a write to a sole clean line needs no bus command
   a_r7_clean_write_local: assert property (@(posedge clk) disable iff (!rst_n)
      accept && cpu_we && line_hit && (ln_st == LN_SC) |=> !bus_req);
endmodule

// File: rtl/wi_snoop_cache.sv
module wi_snoop_cache
   import coh_pkg::*;
#(
   parameter int ADDR_W          = 8,
   parameter int IDX_W           = 3,
   parameter int DATA_W          = 32,
   parameter bit STALL_ANY_SNOOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_shared_in,
   input  logic              snp_vld,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_data
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("wi_snoop_cache: IDX_W must be in 1..ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("wi_snoop_cache: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  cpu_idx, snp_idx;
   logic [TAG_W-1:0]  snp_tag;
   logic [1:0]        lk_st, sn_st, own_st, upd_st;
   logic [TAG_W-1:0]  lk_tag, sn_tag, own_tag;
   logic [DATA_W-1:0] lk_data, sn_data, own_data;
   logic              own_we, upd_we, snp_block;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

   if (STALL_ANY_SNOOP) begin : g_stall_all
      assign snp_block = snp_vld;
   end else begin : g_stall_line
      assign snp_block = snp_vld && (snp_idx == cpu_idx);
   end

   coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (cpu_idx),
      .lk_st    (lk_st),
      .lk_tag   (lk_tag),
      .lk_data  (lk_data),
      .sn_idx   (snp_idx),
      .sn_st    (sn_st),
      .sn_tag   (sn_tag),
      .sn_data  (sn_data),
      .own_we   (own_we),
      .own_idx  (cpu_idx),
      .own_st   (own_st),
      .own_tag  (own_tag),
      .own_data (own_data),
      .upd_we   (upd_we),
      .upd_idx  (snp_idx),
      .upd_st   (upd_st)
   );

   coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_vld    (snp_vld),
      .snp_cmd    (snp_cmd),
      .snp_tag    (snp_tag),
      .ln_st      (sn_st),
      .ln_tag     (sn_tag),
      .ln_data    (sn_data),
      .snp_shared (snp_shared),
      .snp_supply (snp_supply),
      .snp_data   (snp_data),
      .upd_we     (upd_we),
      .upd_st     (upd_st)
   );

   coh_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .cpu_ready     (cpu_ready),
      .cpu_hit       (cpu_hit),
      .cpu_rdata     (cpu_rdata),
      .ln_st         (lk_st),
      .ln_tag        (lk_tag),
      .ln_data       (lk_data),
      .snp_block     (snp_block),
      .bus_req       (bus_req),
      .bus_cmd       (bus_cmd),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_gnt       (bus_gnt),
      .bus_done      (bus_done),
      .bus_rdata     (bus_rdata),
      .bus_shared_in (bus_shared_in),
      .own_we        (own_we),
      .own_st        (own_st),
      .own_tag       (own_tag),
      .own_data      (own_data)
   );

   // R4: data is supplied only by a cache that reports a copy
   a_r4_supply_needs_copy: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> snp_shared);

   // R10: after a snooped write-miss hits, the same address finds no copy
   a_r10_wrmiss_drops_copy: assert property (@(posedge clk) disable iff (!rst_n)
      snp_vld && (snp_cmd == BC_WRMISS) && snp_shared
      |=> !(snp_vld && (snp_addr == $past(snp_addr)) && snp_shared));
endmodule

// File: tb/test_wi_snoop_cache.sv
`timescale 1ns/1ps
module test_wi_snoop_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready, cpu_hit;
   logic [31:0] cpu_rdata;
   logic        bus_req;
   logic [1:0]  bus_cmd;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_gnt = 1'b0, bus_done = 1'b0, bus_shared_in = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        snp_vld = 1'b0;
   logic [1:0]  snp_cmd = '0;
   logic [7:0]  snp_addr = '0;
   logic        snp_shared, snp_supply;
   logic [31:0] snp_data;

   int total = 0;
   int bad = 0;
   int nlog;
   logic [1:0]  log_cmd  [4];
   logic [7:0]  log_addr [4];
   logic [31:0] log_wd   [4];

   always #2.5 clk = ~clk;

   wi_snoop_cache i_wi_snoop_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
      .bus_shared_in(bus_shared_in),
      .snp_vld(snp_vld), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        input logic sh, input logic [31:0] fill,
                        output logic [31:0] rd, output logic hit);
      int  phase = 0;
      bit  got = 0;
      nlog = 0;
      rd = '0;
      hit = 1'b0;
      for (int c = 0; c < 60 && !got; c++) begin
         @(negedge clk);
         bus_gnt = 1'b0; bus_done = 1'b0; bus_shared_in = 1'b0;
         if (phase == 1) begin
            bus_done = 1'b1; bus_rdata = fill; bus_shared_in = sh; phase = 0;
         end
         cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
         #1;
         if (cpu_ready) begin
            rd = cpu_rdata; hit = cpu_hit; got = 1;
         end else if (bus_req) begin
            if (nlog < 4) begin
               log_cmd[nlog] = bus_cmd; log_addr[nlog] = bus_addr; log_wd[nlog] = bus_wdata;
            end
            nlog++;
            bus_gnt = 1'b1;
            phase = 1;
         end
      end
      @(negedge clk);
      cpu_req = 1'b0; bus_gnt = 1'b0; bus_done = 1'b0; bus_shared_in = 1'b0;
      if (!got) chk("R11 access completion", 32'd0, 32'd1);
   endtask

   task automatic do_snp(input logic [1:0] cmd, input logic [7:0] a,
                         output logic sh, output logic sup, output logic [31:0] d);
      @(negedge clk);
      snp_vld = 1'b1; snp_cmd = cmd; snp_addr = a;
      #1;
      sh = snp_shared; sup = snp_supply; d = snp_data;
      @(negedge clk);
      snp_vld = 1'b0;
   endtask

   logic [31:0] rd, d;
   logic        hit, sh, sup;

   task automatic t_reset();
      @(negedge clk); #1;
      chk("R1 no request after reset", {31'd0, bus_req}, 32'd0);
      chk("R1 no ready after reset", {31'd0, cpu_ready}, 32'd0);
      do_op(1'b0, 8'h01, '0, 1'b0, 32'hA000_0001, rd, hit);
      chk("R1 first read misses", nlog, 1);
      chk("R11 read-miss code", {30'd0, log_cmd[0]}, 32'd0);
      chk("R11 read-miss address", {24'd0, log_addr[0]}, 32'h01);
      chk("R2 fill data returned", rd, 32'hA000_0001);
      chk("R13 miss reports no hit", {31'd0, hit}, 32'd0);
   endtask

   task automatic t_clean_write();
      do_op(1'b1, 8'h01, 32'hB000_0001, 1'b0, '0, rd, hit);
      chk("R2 R7 sole clean write issues no command", nlog, 0);
      chk("R13 write hit reports hit", {31'd0, hit}, 32'd1);
      do_snp(BC_RDMISS_T, 8'h01, sh, sup, d);
      chk("R7 line became modified: shared", {31'd0, sh}, 32'd1);
      chk("R4 modified line supplies", {31'd0, sup}, 32'd1);
      chk("R4 supplied data", d, 32'hB000_0001);
      do_op(1'b1, 8'h01, 32'hB000_0002, 1'b0, '0, rd, hit);
      chk("R4 R8 shared write issues one command", nlog, 1);
      chk("R8 invalidate code", {30'd0, log_cmd[0]}, 32'd2);
      chk("R8 invalidate address", {24'd0, log_addr[0]}, 32'h01);
      chk("R8 still a hit", {31'd0, hit}, 32'd1);
      do_snp(BC_RDMISS_T, 8'h01, sh, sup, d);
      chk("R8 line modified after upgrade", {31'd0, sup}, 32'd1);
      chk("R8 written data kept", d, 32'hB000_0002);
   endtask

   task automatic t_shared_fill();
      do_op(1'b0, 8'h02, '0, 1'b1, 32'hA000_0002, rd, hit);
      chk("R3 read miss command", {30'd0, log_cmd[0]}, 32'd0);
      do_op(1'b1, 8'h02, 32'hB000_0003, 1'b0, '0, rd, hit);
      chk("R3 shared fill needs invalidate on write", nlog, 1);
      chk("R3 invalidate code", {30'd0, log_cmd[0]}, 32'd2);
      do_op(1'b0, 8'h02, '0, 1'b0, '0, rd, hit);
      chk("R9 read hit no command", nlog, 0);
      chk("R9 read hit data", rd, 32'hB000_0003);
      chk("R9 read hit flagged", {31'd0, hit}, 32'd1);
      do_op(1'b1, 8'h02, 32'hB000_0004, 1'b0, '0, rd, hit);
      chk("R6 modified write no command", nlog, 0);
      do_snp(BC_RDMISS_T, 8'h02, sh, sup, d);
      chk("R6 still modified", {31'd0, sup}, 32'd1);
      chk("R6 new data", d, 32'hB000_0004);
   endtask

   task automatic t_write_miss();
      do_op(1'b1, 8'h03, 32'hB000_0005, 1'b0, 32'hA000_0003, rd, hit);
      chk("R5 one command", nlog, 1);
      chk("R5 write-miss code", {30'd0, log_cmd[0]}, 32'd1);
      chk("R5 write-miss address", {24'd0, log_addr[0]}, 32'h03);
      chk("R13 write miss no hit", {31'd0, hit}, 32'd0);
      do_op(1'b0, 8'h03, '0, 1'b0, '0, rd, hit);
      chk("R5 written data read back", rd, 32'hB000_0005);
      chk("R5 read back without command", nlog, 0);
      do_snp(BC_WRMISS_T, 8'h03, sh, sup, d);
      chk("R10 write-miss snoop shared", {31'd0, sh}, 32'd1);
      chk("R10 write-miss snoop supplies", {31'd0, sup}, 32'd1);
      chk("R10 write-miss snoop data", d, 32'hB000_0005);
      do_snp(BC_RDMISS_T, 8'h03, sh, sup, d);
      chk("R10 copy dropped after write-miss", {31'd0, sh}, 32'd0);
      do_op(1'b0, 8'h03, '0, 1'b0, 32'hA000_0004, rd, hit);
      chk("R10 dropped line misses", nlog, 1);
   endtask

   task automatic t_invalidate();
      do_snp(BC_INVAL_T, 8'h03, sh, sup, d);
      chk("R10 invalidate raises no shared", {31'd0, sh}, 32'd0);
      do_snp(BC_RDMISS_T, 8'h03, sh, sup, d);
      chk("R10 copy dropped after invalidate", {31'd0, sh}, 32'd0);
      do_op(1'b0, 8'h04, '0, 1'b0, 32'hA000_0005, rd, hit);
      do_snp(BC_RDMISS_T, 8'h24, sh, sup, d);
      chk("R10 tag mismatch not shared", {31'd0, sh}, 32'd0);
      do_snp(BC_RDMISS_T, 8'h04, sh, sup, d);
      chk("R10 clean copy shared", {31'd0, sh}, 32'd1);
      chk("R10 clean copy not supplied", {31'd0, sup}, 32'd0);
   endtask

   task automatic t_read_hit_clean();
      do_op(1'b0, 8'h05, '0, 1'b0, 32'hA000_0006, rd, hit);
      do_op(1'b0, 8'h05, '0, 1'b0, '0, rd, hit);
      chk("R9 clean read hit data", rd, 32'hA000_0006);
      chk("R9 clean read hit no command", nlog, 0);
      do_op(1'b1, 8'h05, 32'hB000_0006, 1'b0, '0, rd, hit);
      chk("R9 state unchanged by read", nlog, 0);
   endtask

   task automatic t_victim();
      do_op(1'b0, 8'h25, '0, 1'b0, 32'hA000_0007, rd, hit);
      chk("R12 two commands", nlog, 2);
      chk("R12 write-back first", {30'd0, log_cmd[0]}, 32'd3);
      chk("R12 write-back address", {24'd0, log_addr[0]}, 32'h05);
      chk("R12 write-back data", log_wd[0], 32'hB000_0006);
      chk("R12 then read-miss", {30'd0, log_cmd[1]}, 32'd0);
      chk("R12 read-miss address", {24'd0, log_addr[1]}, 32'h25);
      chk("R12 new data", rd, 32'hA000_0007);
      do_snp(BC_RDMISS_T, 8'h05, sh, sup, d);
      chk("R12 old line gone", {31'd0, sh}, 32'd0);
      do_op(1'b0, 8'h45, '0, 1'b0, 32'hA000_0008, rd, hit);
      chk("R12 clean victim dropped silently", nlog, 1);
      chk("R12 clean victim read-miss", {30'd0, log_cmd[0]}, 32'd0);
   endtask

   localparam logic [1:0] BC_RDMISS_T = 2'd0;
   localparam logic [1:0] BC_WRMISS_T = 2'd1;
   localparam logic [1:0] BC_INVAL_T  = 2'd2;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_clean_write();
      t_shared_fill();
      t_write_miss();
      t_invalidate();
      t_read_hit_clean();
      t_victim();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule